// File: doc/BRIEF.md
# Masked-Output GPIO Port

This block is a 32-pin general-purpose I/O port behind a minimal 32-bit register bus that has an address, a write strobe, write data and combinational read data. For each pin it stores a direction bit and an output level. It drives the pad output-enable and output-level signals from these two bits. It also returns the pin input levels through a two-flop synchronizer.

Software changes direction with two strobe registers, one that makes pins outputs and one that makes pins inputs. Each strobe touches only the pins whose write-data bit is 1, so two agents can own different pins without a read-modify-write.

Output levels are written one 16-pin half at a time. In each half register, the upper 16 data bits enable the update of the matching lower 16 value bits. A pin keeps its stored level while it is an input. Software can therefore preload a level before it turns the pin into an output.

The port has no state machine. All its state is held in the direction word, the two output halves and the synchronizer chain. Each of these is updated on every clock edge from the decoded bus write.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), every stored output level is 0 (`pin_out` = 0), and reads of 0x04, 0x08, 0x0C and 0x10 return 0.
- R2: A write to address 0x00 sets the direction bit of each pin whose data bit is 1, which makes that pin an output. Pins with a 0 data bit keep their direction.
- R3: A write to address 0x04 clears the direction bit of each pin whose data bit is 1, which makes that pin an input. Pins with a 0 data bit keep their direction.
- R4: A write to address 0x08 updates pin n (0 to 15) to data bit n only when data bit n+16 is 1. All other pins keep their stored level.
- R5: A write to address 0x0C updates pin 16+n to data bit n only when data bit n+16 is 1. All other pins keep their stored level.
- R6: `pin_out` always shows the stored level, whatever the direction. A level written while a pin is an input appears unchanged once the pin becomes an output.
- R7: A read of 0x04 returns the direction word, where 1 means output. A read of 0x08 returns pins 15:0, and a read of 0x0C returns pins 31:16. Both half reads put the levels in bits 15:0 with zero in bits 31:16. Read data is combinational from the address.
- R8: A read of 0x10 returns `pin_in` as sampled two clock edges earlier. A change on `pin_in` becomes visible after the second rising edge, and not after the first.
- R9: Writes to any address other than 0x00, 0x04, 0x08 and 0x0C, including 0x10, change no state. Reads of unmapped addresses (including 0x00) return 0.
- R10: While `bus_we` is 0, no state changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_oe | output | 32 | Pad output enables, 1 = drive |
| pin_out | output | 32 | Pad output levels |

## Verification
Some properties are checked on every cycle by the assertions:
- Each set or clear strobe reaches exactly the pins named in the write data.
- Unmasked output bits and unstrobed direction bits hold.
- An idle bus leaves all state stable.
- Each synchronizer stage copies its predecessor one edge later.

Other behaviour can only be shown by the bench scenarios:
- The two-edge read latency of the input word.
- Preloading a level while a pin is an input and then switching it to an output.
- The zero upper half of the output readback.
- Writes to unmapped or read-only addresses being ignored.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PIN_COUNT = 32;
    localparam int HALF_W    = PIN_COUNT / 2;
    localparam int ADDR_W    = 8;
    localparam int SYNC_LEN  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MAKE_OUT = 8'h00,
        REG_MAKE_IN  = 8'h04,
        REG_LVL_LO   = 8'h08,
        REG_LVL_HI   = 8'h0C,
        REG_PIN_IN   = 8'h10
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign dout = stage_q[STAGES-1];

    // R8: first stage captures the pad word one edge later
    p_first_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[0] == $past(din));

    generate
        if (STAGES > 1) begin : g_chain_chk
            // R8: each later stage follows its predecessor by one edge
            p_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> stage_q[STAGES-1] == $past(stage_q[STAGES-2]));
        end
    endgenerate
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dir_q <= '0;
        else if (set_stb) dir_q <= dir_q | bits;
        else if (clr_stb) dir_q <= dir_q & ~bits;
    end

    // R2: strobed pins become outputs, others hold
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((dir_q & $past(bits)) == $past(bits)) &&
                    (((dir_q ^ $past(dir_q)) & ~$past(bits)) == '0));
    // R3: strobed pins become inputs, others hold
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((dir_q & $past(bits)) == '0) &&
                    (((dir_q ^ $past(dir_q)) & ~$past(bits)) == '0));
    // R10: no strobe, no change
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !set_stb && !clr_stb |=> $stable(dir_q));
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_stb && clr_stb));
endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [HW-1:0] mask,
    input  logic [HW-1:0] value,
    output logic [HW-1:0] lvl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lvl_q <= '0;
        else if (wr_stb) lvl_q <= (lvl_q & ~mask) | (value & mask);
    end

    // R4/R5: masked-off pins keep their level
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ((lvl_q ^ $past(lvl_q)) & ~$past(mask)) == '0);
    // R4/R5: enabled pins take the written value
    p_mask_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ((lvl_q ^ $past(value)) & $past(mask)) == '0);
    // R10: no strobe, level stable
    p_lvl_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(lvl_q));
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [PIN_COUNT-1:0] bus_wdata,
    output logic [PIN_COUNT-1:0] bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pin_out
);
    localparam int HALVES = PIN_COUNT / HALF_W;

    logic                 make_out_stb;
    logic                 make_in_stb;
    logic [HALVES-1:0]    lvl_stb;
    logic [PIN_COUNT-1:0] dir_word;
    logic [PIN_COUNT-1:0] lvl_word;
    logic [PIN_COUNT-1:0] in_sync;

    assign make_out_stb = bus_we && (bus_addr == REG_MAKE_OUT);
    assign make_in_stb  = bus_we && (bus_addr == REG_MAKE_IN);
    assign lvl_stb[0]   = bus_we && (bus_addr == REG_LVL_LO);
    assign lvl_stb[1]   = bus_we && (bus_addr == REG_LVL_HI);

    gpio_dir_reg #(.W(PIN_COUNT)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (make_out_stb),
        .clr_stb (make_in_stb),
        .bits    (bus_wdata),
        .dir_q   (dir_word)
    );

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            gpio_out_half #(.HW(HALF_W)) u_half (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_stb (lvl_stb[h]),
                .mask   (bus_wdata[2*HALF_W-1:HALF_W]),
                .value  (bus_wdata[HALF_W-1:0]),
                .lvl_q  (lvl_word[h*HALF_W +: HALF_W])
            );
        end
    endgenerate

    gpio_in_sync #(.W(PIN_COUNT), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (in_sync)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_MAKE_IN: bus_rdata = dir_word;
            REG_LVL_LO:  bus_rdata = {{(PIN_COUNT-HALF_W){1'b0}}, lvl_word[HALF_W-1:0]};
            REG_LVL_HI:  bus_rdata = {{(PIN_COUNT-HALF_W){1'b0}}, lvl_word[PIN_COUNT-1:HALF_W]};
            REG_PIN_IN:  bus_rdata = in_sync;
            default:     bus_rdata = '0;
        endcase
    end

    assign pin_oe  = dir_word;
    assign pin_out = lvl_word;

    // R9: a write to any unmapped or read-only address leaves all state stable
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !make_out_stb && !make_in_stb && (lvl_stb == '0)
        |=> $stable(pin_oe) && $stable(pin_out));
    // R6: a direction change never disturbs stored levels
    p_dir_keeps_lvl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (make_out_stb || make_in_stb) |=> $stable(pin_out));
endmodule

// File: tb/gpio_masked_port_bench.sv
module gpio_masked_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_dir = '0;
    logic [31:0] exp_lvl = '0;

    always #10 clk = ~clk;

    gpio_masked_port u_gpio_masked_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, commit at the following rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            8'h00: exp_dir = exp_dir | d;
            8'h04: exp_dir = exp_dir & ~d;
            8'h08: exp_lvl[15:0]  = (exp_lvl[15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
            8'h0C: exp_lvl[31:16] = (exp_lvl[31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        check(req, pin_oe, exp_dir);
        check(req, pin_out, exp_lvl);
        rd(8'h04, v); check({req, " R7 dir readback"}, v, exp_dir);
        rd(8'h08, v); check({req, " R7 lo readback"}, v, {16'h0, exp_lvl[15:0]});
        rd(8'h0C, v); check({req, " R7 hi readback"}, v, {16'h0, exp_lvl[31:16]});
    endtask

    initial begin
        #3000000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_state("R1");
        rd(8'h10, v); check("R1 input word", v, 32'h0);

        // R2 walking set, sparse patterns
        for (int i = 0; i < 32; i += 3) begin
            wr(8'h00, 32'h1 << i);
            check("R2 single set", pin_oe, exp_dir);
        end
        wr(8'h00, 32'h0);
        check("R2 zero set", pin_oe, exp_dir);
        wr(8'h00, 32'hF0F0_0F0F);
        check_state("R2");

        // R3 clears
        for (int i = 0; i < 32; i += 5) begin
            wr(8'h04, 32'h1 << i);
            check("R3 single clear", pin_oe, exp_dir);
        end
        wr(8'h04, 32'hFFFF_0000);
        check_state("R3");
        wr(8'h04, 32'hFFFF_FFFF);
        check("R3 all inputs", pin_oe, 32'h0);

        // R4 / R5 mask sweeps with arithmetic patterns
        for (int k = 0; k < 48; k++) begin
            logic [15:0] m;
            logic [15:0] d;
            m = 16'(k * 16'h9E37) ^ 16'(k << 3);
            d = 16'(k * 16'h3B1F + 7);
            wr(8'h08, {m, d});
            check("R4 lo masked", pin_out, exp_lvl);
            wr(8'h0C, {~m, d ^ 16'hA5A5});
            check("R5 hi masked", pin_out, exp_lvl);
        end
        wr(8'h08, 32'h0000_FFFF);
        check("R4 empty mask", pin_out, exp_lvl);
        wr(8'h0C, 32'hFFFF_1234);
        check_state("R5");

        // R6 preload while input, then switch to output
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_C3A5);
        wr(8'h0C, 32'hFFFF_5A3C);
        check("R6 preload level", pin_out, 32'h5A3C_C3A5);
        wr(8'h00, 32'hFFFF_FFFF);
        check("R6 level kept on enable", pin_out, 32'h5A3C_C3A5);
        check("R6 all outputs", pin_oe, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0F0F_0F0F);
        check("R6 level kept on disable", pin_out, 32'h5A3C_C3A5);

        // R10 bus_we low: no state change
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 32'hFFFF_0000;
        @(negedge clk);
        check_state("R10");

        // R9 unmapped and read-only writes
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_0000);
        wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'h09, 32'hFFFF_0000);
        check_state("R9");
        rd(8'h00, v); check("R9 read 0x00", v, 32'h0);
        rd(8'h14, v); check("R9 read 0x14", v, 32'h0);

        // R8 two-edge input latency
        prev = 32'h0;
        for (int k = 0; k < 12; k++) begin
            logic [31:0] nv;
            nv = 32'(k * 32'h9E37_79B9) ^ 32'(k << 20);
            @(negedge clk);
            pin_in = nv;
            rd(8'h10, v); check("R8 no change yet", v, prev);
            @(negedge clk);
            rd(8'h10, v); check("R8 after one edge", v, prev);
            @(negedge clk);
            rd(8'h10, v); check("R8 after two edges", v, nv);
            prev = nv;
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule